// File: doc/BRIEF.md
# Reset Exception Entry Controller

This block handles how a 32-bit processor core enters its system reset exception. It watches two asynchronous reset requests, a soft one and a hard one, and takes the exception when either occurs. The exception cannot be masked. On entry it writes three registered outputs: the saved return address, the saved state word and the new machine state word. It also picks the handler address from the exception prefix bit and issues the first instruction fetch of the handler as a single-beat, cache-inhibited request that stays asserted until it is acknowledged.

Both reset requests pass through a synchronizer. The exception is taken on a rising edge of the soft request, and on the first clock after the hard request is released. While the hard request is held, it also acts as the block's synchronous active-high reset and clears every register. The hard exception is therefore built from an all-zero machine state. The block owns the software-visible "no hard reset seen" flag. Software sets this flag. A hard reset clears it and a soft reset leaves it alone, so a handler can read it to tell which kind of reset occurred.

Bit numbering in the requirements is little-endian, with bit 0 the least significant. The architectural big-endian number of a bit is 31 minus its index.

Top module: `rst_entry_ctrl`

## Requirements
- R1: A rising edge on soft_rst_i takes the exception. taken_o pulses high for exactly one cycle, on the third clock edge after the input rises. Holding soft_rst_i high does not take the exception again.
- R2: While hard_rst_i is held, all outputs are 0 and no exception is taken. On the third clock edge after hard_rst_i falls, taken_o pulses high. At that point srr0_o, srr1_o and msr_o are all 0, and vector_o is 0x0000_0100.
- R3: vector_o is 0xFFF0_0100 when bit 6 (the prefix bit) of the entry MSR is 1. It is 0x0000_0100 when that bit is 0.
- R4: On a soft-reset entry, srr0_o is loaded with nia_i.
- R5: srr1_o is loaded with the entry MSR ANDed with 0x87C0_FFFF. This keeps bits 31, 26 to 22 and 15 to 0, and clears all other bits.
- R6: When unrecoverable_i is 1 at entry, srr1_o bit 1 (the recoverable bit) is forced to 0.
- R7: msr_o keeps bit 16 (interrupt endian), bit 12 (machine check enable) and bit 6 (prefix) of the entry MSR. Its bit 0 (endian) is set to entry bit 16. Every other bit is cleared.
- R8: nhr_o is set one cycle after a pulse on nhr_set_i. A hard reset clears it. A soft-reset entry leaves it unchanged.
- R9: From the taken_o cycle onward, fetch_valid_o, fetch_single_o and fetch_ci_o are 1 and fetch_addr_o equals vector_o. These signals stay that way until fetch_ack_i is seen high on a clock edge, and all three flags are 0 after that edge.
- R10: A soft-reset edge that arrives while the hard reset is active is ignored. The only entry taken is the hard-reset entry on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_i | input | 1 | Asynchronous hard reset request; synchronized, also clears the block |
| soft_rst_i | input | 1 | Asynchronous soft reset request; synchronized, rising edge taken |
| msr_i | input | 32 | Current machine state word of the core |
| nia_i | input | 32 | Address of the instruction that would execute next |
| unrecoverable_i | input | 1 | Core state cannot be resumed reliably |
| nhr_set_i | input | 1 | Software write setting the no-hard-reset flag |
| fetch_ack_i | input | 1 | Fetch request accepted |
| taken_o | output | 1 | One-cycle pulse: exception entered |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved state word |
| msr_o | output | 32 | Machine state word after entry |
| vector_o | output | 32 | Handler address |
| nhr_o | output | 1 | No-hard-reset flag |
| fetch_valid_o | output | 1 | First handler fetch pending |
| fetch_addr_o | output | 32 | Address of the pending fetch |
| fetch_single_o | output | 1 | Pending fetch is single-beat |
| fetch_ci_o | output | 1 | Pending fetch is cache-inhibited |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, offset 0x100 and high base 0xFFF0_0000. With these values the entry latency is a fixed three cycles, so every check can land on the exact entry cycle. The vector table drives MSR patterns through soft-reset entries. The patterns set every kept field, every cleared field, the prefix bit and the recoverable-bit override. Directed cases cover hard-reset hold and release, a soft edge masked by a hard reset, a held soft request, fetch hold until acknowledgement, and the flag behaviour.

// File: rtl/rec_pkg.sv
package rec_pkg;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] SRR1_KEEP = 32'h87C0_FFFF;
  localparam int ILE_BIT = 16;
  localparam int ME_BIT  = 12;
  localparam int IP_BIT  = 6;
  localparam int RI_BIT  = 1;
  localparam int LE_BIT  = 0;
  localparam logic [XLEN-1:0] MSR_KEEP =
    (XLEN'(1) << ILE_BIT) | (XLEN'(1) << ME_BIT) | (XLEN'(1) << IP_BIT);

  typedef struct packed {
    logic [XLEN-1:0] srr0;
    logic [XLEN-1:0] srr1;
    logic [XLEN-1:0] msr;
    logic [XLEN-1:0] vec;
  } entry_t;
endpackage

// File: rtl/rec_sync.sv
module rec_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];
  always_ff @(posedge clk) chain[0] <= d;
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) chain[i] <= chain[i-1];
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/rec_state_calc.sv
module rec_state_calc
  import rec_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_OFFSET = 32'h0000_0100,
  parameter logic [XLEN-1:0] HI_BASE    = 32'hFFF0_0000
) (
  input  logic [XLEN-1:0] msr,
  input  logic [XLEN-1:0] nia,
  input  logic            unrec,
  output entry_t          ent
);
  always_comb begin
    ent.srr0 = nia;
    ent.srr1 = msr & SRR1_KEEP;
    if (unrec) ent.srr1[RI_BIT] = 1'b0;
    ent.msr = msr & MSR_KEEP;
    ent.msr[LE_BIT] = msr[ILE_BIT];
    ent.vec = msr[IP_BIT] ? (HI_BASE | VEC_OFFSET) : VEC_OFFSET;
  end
endmodule

// File: rtl/rec_fetch_req.sv
module rec_fetch_req #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic          ack,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic          single,
  output logic          ci
);
  always_ff @(posedge clk) begin
    if (clr) begin
      valid  <= 1'b0;
      single <= 1'b0;
      ci     <= 1'b0;
      addr   <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      single <= 1'b1;
      ci     <= 1'b1;
      addr   <= addr_in;
    end else if (valid && ack) begin
      valid  <= 1'b0;
      single <= 1'b0;
      ci     <= 1'b0;
    end
  end
endmodule

// File: rtl/rst_entry_ctrl.sv
module rst_entry_ctrl
  import rec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0100,
  parameter logic [31:0] HI_BASE    = 32'hFFF0_0000
) (
  input  logic        clk,
  input  logic        hard_rst_i,
  input  logic        soft_rst_i,
  input  logic [31:0] msr_i,
  input  logic [31:0] nia_i,
  input  logic        unrecoverable_i,
  input  logic        nhr_set_i,
  input  logic        fetch_ack_i,
  output logic        taken_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic [31:0] msr_o,
  output logic [31:0] vector_o,
  output logic        nhr_o,
  output logic        fetch_valid_o,
  output logic [31:0] fetch_addr_o,
  output logic        fetch_single_o,
  output logic        fetch_ci_o
);
  logic [1:0] rq_sync;
  logic       hard_act, soft_sync, hard_prev, soft_prev;
  logic       hard_rel, soft_edge, take;
  logic [XLEN-1:0] src_msr, src_nia;
  logic       src_unrec;
  entry_t     ent;

  rec_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .d({hard_rst_i, soft_rst_i}), .q(rq_sync)
  );
  assign hard_act  = rq_sync[1];
  assign soft_sync = rq_sync[0];

  always_ff @(posedge clk) begin
    hard_prev <= hard_act;
    soft_prev <= soft_sync;
  end

  assign hard_rel  = hard_prev && !hard_act;
  assign soft_edge = soft_sync && !soft_prev && !hard_act;
  assign take      = hard_rel || soft_edge;

  // A hard entry is built from the cleared state, a soft one from live inputs.
  assign src_msr   = hard_rel ? '0 : msr_i;
  assign src_nia   = hard_rel ? '0 : nia_i;
  assign src_unrec = hard_rel ? 1'b0 : unrecoverable_i;

  rec_state_calc #(.VEC_OFFSET(VEC_OFFSET), .HI_BASE(HI_BASE)) u_calc (
    .msr(src_msr), .nia(src_nia), .unrec(src_unrec), .ent(ent)
  );

  always_ff @(posedge clk) begin
    if (hard_act) begin
      taken_o  <= 1'b0;
      srr0_o   <= '0;
      srr1_o   <= '0;
      msr_o    <= '0;
      vector_o <= '0;
      nhr_o    <= 1'b0;
    end else begin
      taken_o <= take;
      if (take) begin
        srr0_o   <= ent.srr0;
        srr1_o   <= ent.srr1;
        msr_o    <= ent.msr;
        vector_o <= ent.vec;
      end
      if (nhr_set_i) nhr_o <= 1'b1;
    end
  end

  rec_fetch_req #(.AW(XLEN)) u_fetch (
    .clk(clk), .clr(hard_act), .load(take), .addr_in(ent.vec),
    .ack(fetch_ack_i), .valid(fetch_valid_o), .addr(fetch_addr_o),
    .single(fetch_single_o), .ci(fetch_ci_o)
  );
endmodule

// File: rtl/rst_entry_ctrl_chk.sv
module rst_entry_ctrl_chk (
  input logic        clk,
  input logic        hard_act,
  input logic        taken_o,
  input logic [31:0] srr1_o,
  input logic [31:0] msr_o,
  input logic [31:0] vector_o,
  input logic        nhr_o,
  input logic        fetch_valid_o,
  input logic [31:0] fetch_addr_o,
  input logic        fetch_single_o,
  input logic        fetch_ci_o,
  input logic        fetch_ack_i
);
  AST_TAKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (hard_act)
    taken_o |=> !taken_o); // R1
  AST_HARD_NO_TAKE: assert property (@(posedge clk)
    hard_act |=> !taken_o); // R2
  AST_VECTOR_PREFIX: assert property (@(posedge clk) disable iff (hard_act)
    taken_o |-> (vector_o == (msr_o[6] ? 32'hFFF0_0100 : 32'h0000_0100))); // R3
  AST_SRR1_CLEARED: assert property (@(posedge clk) disable iff (hard_act)
    taken_o |-> ((srr1_o & 32'h783F_0000) == 32'h0)); // R5
  AST_MSR_ENDIAN: assert property (@(posedge clk) disable iff (hard_act)
    taken_o |-> (msr_o[0] == msr_o[16] && (msr_o & 32'hFFFE_EFBE) == 32'h0)); // R7
  AST_NHR_HARD: assert property (@(posedge clk)
    hard_act |=> !nhr_o); // R8
  AST_FETCH_ON_TAKE: assert property (@(posedge clk) disable iff (hard_act)
    taken_o |-> (fetch_valid_o && fetch_addr_o == vector_o)); // R9
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (hard_act)
    (fetch_valid_o && !fetch_ack_i) |=> fetch_valid_o); // R9
  AST_FETCH_ATTR: assert property (@(posedge clk) disable iff (hard_act)
    (fetch_single_o == fetch_valid_o) && (fetch_ci_o == fetch_valid_o)); // R9
endmodule

bind rst_entry_ctrl rst_entry_ctrl_chk u_chk (
  .clk(clk), .hard_act(hard_act), .taken_o(taken_o), .srr1_o(srr1_o),
  .msr_o(msr_o), .vector_o(vector_o), .nhr_o(nhr_o),
  .fetch_valid_o(fetch_valid_o), .fetch_addr_o(fetch_addr_o),
  .fetch_single_o(fetch_single_o), .fetch_ci_o(fetch_ci_o),
  .fetch_ack_i(fetch_ack_i)
);

// File: tb/sim_rst_entry_ctrl.sv
`timescale 1ns/1ps
module sim_rst_entry_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic hard_rst_i, soft_rst_i, unrecoverable_i, nhr_set_i, fetch_ack_i;
  logic [31:0] msr_i, nia_i;
  logic taken_o, nhr_o, fetch_valid_o, fetch_single_o, fetch_ci_o;
  logic [31:0] srr0_o, srr1_o, msr_o, vector_o, fetch_addr_o;

  rst_entry_ctrl u0 (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // msr, nia, unrec, expected srr1, expected msr, expected vector
  localparam int NV = 7;
  localparam logic [32*5+1-1:0] VT [NV] = '{
    {32'hFFFF_FFFF, 32'h0000_1000, 1'b0, 32'h87C0_FFFF, 32'h0001_1041, 32'hFFF0_0100},
    {32'hFFFF_FFFF, 32'h0000_2004, 1'b1, 32'h87C0_FFFD, 32'h0001_1041, 32'hFFF0_0100},
    {32'h0000_0000, 32'hDEAD_BEE0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0100},
    {32'h0001_0000, 32'h1234_5678, 1'b0, 32'h0000_0000, 32'h0001_0001, 32'h0000_0100},
    {32'h7800_0040, 32'hA5A5_A5A4, 1'b0, 32'h0000_0040, 32'h0000_0040, 32'hFFF0_0100},
    {32'h0003_F000, 32'h0000_0FFC, 1'b0, 32'h0000_F000, 32'h0001_1001, 32'h0000_0100},
    {32'h87C0_0002, 32'h8000_0000, 1'b1, 32'h87C0_0000, 32'h0000_0000, 32'h0000_0100}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    hard_rst_i = 1; soft_rst_i = 0; unrecoverable_i = 0; nhr_set_i = 0;
    fetch_ack_i = 0; msr_i = 32'hFFFF_FFFF; nia_i = 32'h0000_1234;
    step(6);
    // R2 reset state
    chk("R2 taken in reset", 32'(taken_o), 0);
    chk("R2 msr in reset", msr_o, 0);
    chk("R2 fetch in reset", 32'(fetch_valid_o), 0);
    chk("R8 flag in reset", 32'(nhr_o), 0);
    hard_rst_i = 0;
    step(2);
    chk("R2 no early take", 32'(taken_o), 0);
    step(1);
    chk("R2 taken on release", 32'(taken_o), 1);
    chk("R2 srr0 zero", srr0_o, 0);
    chk("R2 srr1 zero", srr1_o, 0);
    chk("R2 msr zero", msr_o, 0);
    chk("R2 vector", vector_o, 32'h0000_0100);
    chk("R9 fetch valid", 32'(fetch_valid_o), 1);
    chk("R9 fetch addr", fetch_addr_o, 32'h0000_0100);
    step(1);
    chk("R2 single pulse", 32'(taken_o), 0);
    fetch_ack_i = 1; step(1); fetch_ack_i = 0;
    chk("R9 cleared by ack", 32'(fetch_valid_o), 0);
    chk("R9 single cleared", 32'(fetch_single_o), 0);

    nhr_set_i = 1; step(1); nhr_set_i = 0;
    chk("R8 flag set", 32'(nhr_o), 1);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] m, n, es, em, ev;
      logic u;
      {m, n, u, es, em, ev} = VT[i];
      msr_i = m; nia_i = n; unrecoverable_i = u; soft_rst_i = 1;
      step(2);
      chk("R1 no early take", 32'(taken_o), 0);
      step(1);
      chk("R1 taken", 32'(taken_o), 1);
      chk("R4 srr0", srr0_o, n);
      chk(u ? "R6 srr1" : "R5 srr1", srr1_o, es);
      chk("R7 msr", msr_o, em);
      chk("R3 vector", vector_o, ev);
      chk("R9 fetch addr", fetch_addr_o, ev);
      chk("R9 single", 32'(fetch_single_o), 1);
      chk("R9 ci", 32'(fetch_ci_o), 1);
      chk("R8 soft keeps flag", 32'(nhr_o), 1);
      for (int k = 0; k < 3; k++) begin
        step(1);
        chk("R1 held no retake", 32'(taken_o), 0);
        chk("R9 held until ack", 32'(fetch_valid_o), 1);
      end
      soft_rst_i = 0;
      fetch_ack_i = 1; step(1); fetch_ack_i = 0;
      chk("R9 ack clears", 32'(fetch_valid_o), 0);
      chk("R9 ci clears", 32'(fetch_ci_o), 0);
      step(4);
    end

    // R10 soft edge while hard active
    msr_i = 32'hFFFF_FFFF; nia_i = 32'h5555_0000;
    hard_rst_i = 1; step(1); soft_rst_i = 1;
    for (int k = 0; k < 6; k++) begin
      step(1);
      chk("R10 no take in hard", 32'(taken_o), 0);
    end
    chk("R8 hard clears flag", 32'(nhr_o), 0);
    hard_rst_i = 0;
    step(3);
    chk("R10 hard entry taken", 32'(taken_o), 1);
    chk("R10 srr0 from zero state", srr0_o, 0);
    chk("R10 vector low", vector_o, 32'h0000_0100);
    step(3);
    chk("R10 no soft retake", 32'(taken_o), 0);
    soft_rst_i = 0;
    fetch_ack_i = 1; step(1); fetch_ack_i = 0;
    step(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule